// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block paces one 8-bit successive-approximation conversion at a time for an analog front end. A conversion begins either when software writes 1 to the start flag, or, when strobe triggering is enabled, on a rising edge of an external PWM strobe. The strobe is first re-timed by a two-stage synchronizer. A programmable divider turns the system clock into a one-cycle conversion tick, so all sequencing stays in a single clock domain.

A conversion has two parts. The first is a sample-and-hold phase that drives the hold control high. The second is a nine-tick conversion phase: eight ticks resolve the result bits from MSB to LSB using the comparator decision, and the ninth tick stores the code. When the code is stored, the pending flag is set and the start flag clears on the same edge. When the autozero bit is set, the sample phase is longer and the whole conversion takes twenty ticks.

The analog circuitry itself lies outside the block. Its enables appear only as bits of the control register, which the block holds and reads back.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy, pending, sample/hold, result and the control register read back as 0.
- R2: With the autozero bit (control bit 0) clear, a conversion lasts 13 conversion ticks: sample/hold is high for the first 4 ticks and busy is high for all 13.
- R3: With control bit 0 set, a conversion lasts 20 conversion ticks, of which the first 11 are the sample phase.
- R4: The result is resolved MSB first. Each decision keeps the trial bit when the comparator input is 1 (input at or above the trial code) and clears it otherwise. The 8-bit result is stored on the edge that clears busy and sets pending.
- R5: Control bits 3:2 select the tick period: codes 0, 1, 2 and 3 give one tick every 1, 2, 4 and 8 system clocks.
- R6: With control bit 4 clear, only the software start write triggers a conversion and the strobe is ignored. With bit 4 set, only a synchronized rising strobe edge triggers a conversion and the software start is ignored.
- R7: A trigger that arrives while busy is dropped. It neither lengthens nor restarts the conversion, and no conversion follows it.
- R8: Writing 1 to the pending clear input clears pending. If a completion falls in the same cycle, pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register read-back |
| sw_start | input | 1 | Software write of 1 to the start flag |
| pend_clr | input | 1 | Software write-1-to-clear of pending |
| pwm_strobe | input | 1 | Asynchronous PWM strobe trigger |
| cmp_in | input | 1 | Comparator decision, 1 when input is at or above the trial code |
| sh_ctrl | output | 1 | Sample/hold control, high during the sample phase |
| sar_code | output | 8 | Trial code presented to the converter DAC |
| busy | output | 1 | Start flag read-back, high while converting |
| pend | output | 1 | Conversion pending flag |
| result | output | 8 | Stored conversion result |

## Verification
The bench models the analog input as a comparator that compares a fixed input value with the trial code. It converts the extremes 0x00 and 0xFF as well as alternating and mid-scale patterns, so that a wrong bit order or a wrong keep/clear decision gives a different code. It measures busy and sample/hold in system clocks for each speed code and for autozero mode, which separates the divider ratios from the phase lengths. It also fires triggers of the disabled source and triggers during a conversion, and checks the pending clear both on its own and in the same cycle as a completion.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC conversion sequencer.
// Assumes: consumers import the package; no state lives here.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } seq_phase_t;
endpackage

// File: rtl/conv_tick_gen.sv
// Conversion tick divider: produces a one-system-clock enable every 2**speed
// clocks while run is high, starting one divided period after run rises.
// Assumes: speed is stable during a conversion; counter is held at 0 when idle.
module conv_tick_gen #(
    parameter int SPEED_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SPEED_W-1:0] speed,
    output logic               tick
);
    localparam int CNT_W = (1 << SPEED_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Build the low-bit mask that sets the division ratio.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(speed));
        end
    end

    // Free-running divider count, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && ((cnt & mask) == mask);

    // R5: a divided tick is never followed directly by another one.
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && speed != '0 && $stable(speed)) |=> !tick);
endmodule

// File: rtl/strobe_edge_det.sv
// Strobe re-timer: passes an asynchronous strobe through STAGES flip-flops and
// flags one cycle per rising edge of the re-timed signal.
// Assumes: strobe pulses last longer than one system clock.
module strobe_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain followed by one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !last_q;

    // R6: an edge indication lasts a single cycle.
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sar_seq_core.sv
// Conversion sequencer: runs the sample phase (short or autozero length), then
// DATA_W successive-approximation ticks and one store tick, all on tick.
// Assumes: trig is a single-cycle request; comparator is valid on each tick.
module sar_seq_core
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_STD = 4,
    parameter int SAMPLE_AZ  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              az_mode,
    input  logic              tick,
    input  logic              cmp_in,
    input  logic              pend_clr,
    output logic              busy,
    output logic              sh_ctrl,
    output logic              pend,
    output logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] result
);
    localparam int STEP_W = $clog2(SAMPLE_AZ + DATA_W + 1);

    seq_phase_t        phase;
    logic [STEP_W-1:0] step;
    logic              az_q;
    logic [STEP_W-1:0] samp_last;
    logic [DATA_W-1:0] code_nxt;

    // Last sample-phase step for the mode latched at trigger.
    assign samp_last = az_q ? STEP_W'(SAMPLE_AZ - 1) : STEP_W'(SAMPLE_STD - 1);

    // One approximation decision: settle the current bit, try the next lower.
    always_comb begin
        code_nxt = code;
        for (int i = 0; i < DATA_W; i++) begin
            if (int'(step) == DATA_W - 1 - i) begin
                if (!cmp_in) code_nxt[i] = 1'b0;
                if (i > 0)   code_nxt[i-1] = 1'b1;
            end
        end
    end

    // Phase, step, trial code, result and pending flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            step   <= '0;
            az_q   <= 1'b0;
            code   <= '0;
            result <= '0;
            pend   <= 1'b0;
        end else begin
            if (pend_clr) pend <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (trig) begin
                        phase <= PH_SAMPLE;
                        step  <= '0;
                        az_q  <= az_mode;
                        code  <= {1'b1, {(DATA_W-1){1'b0}}};
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        if (step == samp_last) begin
                            phase <= PH_CONV;
                            step  <= '0;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                PH_CONV: begin
                    if (tick) begin
                        if (int'(step) == DATA_W) begin
                            result <= code;
                            pend   <= 1'b1;
                            phase  <= PH_IDLE;
                        end else begin
                            code <= code_nxt;
                            step <= step + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (phase != PH_IDLE);
    assign sh_ctrl = (phase == PH_SAMPLE);

    // R4: completion sets pending on the edge that ends busy.
    p_done_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pend);
    // R4: the stored result only changes on completion.
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));
    // R8: pending rises only from a completion.
    p_pend_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $fell(busy));
    // R2: sample/hold is only driven inside a conversion.
    p_sh_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_ctrl |-> busy);
endmodule

// File: rtl/adc_conv_seq.sv
// Top of the ADC conversion sequencer: holds the control register, selects the
// trigger source, and ties divider, strobe re-timer and sequencer together.
// Control bits: 4 strobe trigger enable, 3:2 speed, 0 autozero; others held only.
// Assumes: control register is not rewritten during a conversion.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SPEED_W    = 2,
    parameter int SYNC_STG   = 2,
    parameter int SAMPLE_STD = 4,
    parameter int SAMPLE_AZ  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_q,
    input  logic              sw_start,
    input  logic              pend_clr,
    input  logic              pwm_strobe,
    input  logic              cmp_in,
    output logic              sh_ctrl,
    output logic [DATA_W-1:0] sar_code,
    output logic              busy,
    output logic              pend,
    output logic [DATA_W-1:0] result
);
    localparam int BIT_AZ    = 0;
    localparam int BIT_SPD   = 2;
    localparam int BIT_STROB = 4;

    logic tick;
    logic strobe_rise;
    logic trig;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    // Only the source chosen by the trigger-select bit may start a conversion.
    assign trig = ctl_q[BIT_STROB] ? strobe_rise : sw_start;

    conv_tick_gen #(.SPEED_W(SPEED_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .speed (ctl_q[BIT_SPD +: SPEED_W]),
        .tick  (tick)
    );

    strobe_edge_det #(.STAGES(SYNC_STG)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (pwm_strobe),
        .rise         (strobe_rise)
    );

    sar_seq_core #(
        .DATA_W     (DATA_W),
        .SAMPLE_STD (SAMPLE_STD),
        .SAMPLE_AZ  (SAMPLE_AZ)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .az_mode  (ctl_q[BIT_AZ]),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .pend_clr (pend_clr),
        .busy     (busy),
        .sh_ctrl  (sh_ctrl),
        .pend     (pend),
        .code     (sar_code),
        .result   (result)
    );

    // R7: a trigger while busy does not restart the sample phase.
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sh_ctrl) |=> (!sh_ctrl || !busy || $past(!busy)));
endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_q;
    logic       sw_start = 1'b0;
    logic       pend_clr = 1'b0;
    logic       pwm_strobe = 1'b0;
    logic       cmp_in;
    logic       sh_ctrl;
    logic [7:0] sar_code;
    logic       busy;
    logic       pend;
    logic [7:0] result;
    logic [7:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    // Comparator model of the analog input.
    assign cmp_in = (vin >= sar_code);

    adc_conv_seq i_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .sw_start(sw_start), .pend_clr(pend_clr),
        .pwm_strobe(pwm_strobe), .cmp_in(cmp_in), .sh_ctrl(sh_ctrl),
        .sar_code(sar_code), .busy(busy), .pend(pend), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic clear_pend();
        @(negedge clk); pend_clr = 1'b1;
        @(negedge clk); pend_clr = 1'b0;
    endtask

    // Count negedges with busy / sh high until busy drops; optional extra trigger.
    task automatic measure(output int nbusy, output int nsh, input bit poke);
        nbusy = 0; nsh = 0;
        while (busy && nbusy < 400) begin
            nbusy++;
            if (sh_ctrl) nsh++;
            if (poke && nbusy == 6) begin sw_start = 1'b1; pwm_strobe = 1'b1; end
            else if (poke && nbusy == 7) sw_start = 1'b0;
            @(negedge clk);
        end
        pwm_strobe = 1'b0;
    endtask

    task automatic sw_conv(input logic [7:0] v, input int div, input bit az, input bit poke);
        int nb, ns;
        vin = v;
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        measure(nb, ns, poke);
        check(nb == (az ? 20 : 13) * div, az ? "R3 busy length" : "R2/R5 busy length", nb, (az ? 20 : 13) * div);
        check(ns == (az ? 11 : 4) * div, az ? "R3 sample length" : "R2 sample length", ns, (az ? 11 : 4) * div);
        check(result == v, "R4 result", result, v);
        check(pend == 1'b1, "R4 pending set", pend, 1);
    endtask

    task automatic t_reset();
        check(busy == 0 && pend == 0 && sh_ctrl == 0, "R1 flags", {busy, pend, sh_ctrl}, 0);
        check(result == 0 && ctl_q == 0, "R1 regs", {ctl_q, result}, 0);
    endtask

    task automatic t_patterns();
        sw_conv(8'h00, 1, 0, 0); clear_pend();
        sw_conv(8'hFF, 1, 0, 0); clear_pend();
        sw_conv(8'hA5, 1, 0, 0); clear_pend();
        sw_conv(8'h5A, 1, 0, 0);
        clear_pend();
        check(pend == 0, "R8 clear alone", pend, 0);
    endtask

    task automatic t_speeds();
        for (int s = 1; s < 4; s++) begin
            write_ctl(8'(s << 2));
            sw_conv(8'h37 + 8'(s), 1 << s, 0, 0);
            clear_pend();
        end
        write_ctl(8'h01);
        sw_conv(8'h81, 1, 1, 0); clear_pend();
        write_ctl(8'h05);
        sw_conv(8'h7E, 2, 1, 0); clear_pend();
        write_ctl(8'h00);
    endtask

    task automatic t_ignore_busy();
        sw_conv(8'h3C, 1, 0, 1);
        repeat (8) begin
            @(negedge clk);
            check(busy == 0, "R7 no queued trigger", busy, 0);
        end
        clear_pend();
    endtask

    task automatic t_sources();
        int nb, ns;
        vin = 8'hC3;
        @(negedge clk); pwm_strobe = 1'b1;
        repeat (6) @(negedge clk);
        check(busy == 0, "R6 strobe ignored when disabled", busy, 0);
        pwm_strobe = 1'b0;
        write_ctl(8'h10);
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 0, "R6 software start ignored in strobe mode", busy, 0);
        pwm_strobe = 1'b1;
        repeat (4) @(negedge clk);
        check(busy == 1, "R6 strobe trigger", busy, 1);
        measure(nb, ns, 0);
        check(result == 8'hC3, "R6 strobe result", result, 8'hC3);
        pwm_strobe = 1'b1;
        repeat (20) @(negedge clk);
        check(busy == 0, "R6 held strobe no retrigger", busy, 0);
        pwm_strobe = 1'b0;
        write_ctl(8'h00);
        clear_pend();
    endtask

    task automatic t_clear_race();
        int n;
        vin = 8'h99;
        check(pend == 0, "R8 precondition", pend, 0);
        sw_conv(8'h99, 1, 0, 0);
        vin = 8'h66;
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        n = 1;
        while (n < 13) begin @(negedge clk); n++; end
        pend_clr = 1'b1;
        @(negedge clk); pend_clr = 1'b0;
        check(busy == 0, "R8 race completion", busy, 0);
        check(pend == 1, "R8 completion beats clear", pend, 1);
        check(result == 8'h66, "R8 race result", result, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_speeds();
        t_ignore_busy();
        t_sources();
        t_clear_race();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule